// File: doc/BRIEF.md
# Accumulator ALU with Dropoff Shifter

This block is the combinational datapath of a small accumulator machine. Each cycle it takes the accumulator value, one operand register value, a 4-bit operation code and the stored dropoff flag. It returns the new accumulator value together with two flag updates, each paired with its own write enable. The surrounding core holds the registers and flags and writes them only where an enable is high.

The shifts take their distance from the operand register. The bit shifted out last is reported as the new dropoff flag. The chained variants feed the previous dropoff bit into the end of the byte that was vacated, so a multi-byte value can be shifted one byte at a time. Addition flags unsigned carry-out. Subtraction flags signed two's-complement overflow.

Top module: `acc_alu`

## Requirements
- R1: Codes 0, 1, 2 and 3 return acc AND opnd, acc OR opnd, NOT(acc AND opnd) and NOT(acc OR opnd).
- R2: Code 4 returns (acc + opnd) mod 256, with ovf_o = 1 exactly when the unsigned sum exceeds 255, and ovf_we_o = 1.
- R3: Code 5 returns (acc - opnd) mod 256, with ovf_o = 1 exactly when the signed difference lies outside -128..127, and ovf_we_o = 1.
- R4: For every code other than 4 and 5, ovf_we_o and ovf_o are both 0.
- R5: Code 6 (logical right shift) with opnd from 1 to 7 fills with zeros and sets drop_o = acc[opnd-1], with drop_we_o = 1.
- R6: Code 7 (chained right shift) behaves like code 6, except that result bit 7 is drop_i.
- R7: Code 8 (logical left shift) with opnd from 1 to 7 fills with zeros and sets drop_o = acc[8-opnd], with drop_we_o = 1.
- R8: Code 9 (chained left shift) behaves like code 8, except that result bit 0 is drop_i.
- R9: Code 10 (arithmetic right shift) with opnd from 1 to 7 fills with copies of acc[7] and sets drop_o = acc[opnd-1], with drop_we_o = 1.
- R10: For codes 6 to 10, when opnd is 8 or more the result is fully shifted, with drop_we_o = 1. Codes 6 and 8 give 0, codes 7 and 9 give drop_i at bit 7 and bit 0 with zeros elsewhere, and all of these set drop_o = 0. Code 10 gives eight copies of acc[7] and sets drop_o = acc[7].
- R11: For codes 6 to 10, when opnd is 0 the result equals acc and drop_we_o = 0.
- R12: Code 11 rotates acc left by opnd mod 8 and keeps drop_we_o = 0.
- R13: Code 12 returns opnd, code 13 returns NOT opnd, and codes 14 and 15 return acc. None of these four asserts a write enable.
- R14: drop_o is 0 whenever drop_we_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand register value, also the shift distance |
| op_i | input | 4 | Operation code |
| drop_i | input | 1 | Stored dropoff flag |
| res_o | output | 8 | New accumulator value |
| ovf_o | output | 1 | New overflow flag |
| ovf_we_o | output | 1 | Overflow flag write enable |
| drop_o | output | 1 | New dropoff flag |
| drop_we_o | output | 1 | Dropoff flag write enable |

## Verification
In a chained shift, the dropoff flag is read and rewritten by the same operation. The old value lands at one end of the result while the bit leaving the other end becomes the new value. Both chained codes are driven with drop_i opposite to the bit that leaves, at every shift distance including 0 and the saturating ones. A bit-serial model in the scoreboard predicts both outputs, so a design that inserts the new bit instead of the old one, or that drops the insertion after saturation, disagrees on either the result or drop_o.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_NAND = 4'd2,
    OP_NOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_SHR  = 4'd6,
    OP_SHRC = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHLC = 4'd9,
    OP_SAR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_MOV  = 4'd12,
    OP_MOVN = 4'd13,
    OP_HLD0 = 4'd14,
    OP_HLD1 = 4'd15
  } alu_op_e;

  function automatic logic is_dist_shift(input alu_op_e op);
    return (op == OP_SHR) || (op == OP_SHRC) || (op == OP_SHL) ||
           (op == OP_SHLC) || (op == OP_SAR);
  endfunction

endpackage

// File: rtl/acc_logic_unit.sv
module acc_logic_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] y_o
);

  logic [W-1:0] conj;
  logic [W-1:0] disj;

  assign conj = a_i & b_i;
  assign disj = a_i | b_i;

  always_comb begin
    case (sel_i)
      2'd0:    y_o = conj;
      2'd1:    y_o = disj;
      2'd2:    y_o = ~conj;
      default: y_o = ~disj;
    endcase
  end

endmodule

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o,
  output logic         ovf_o
);

  logic [W:0]   sum_w;
  logic [W-1:0] diff;
  logic         sgn_ovf;

  assign sum_w   = {1'b0, a_i} + {1'b0, b_i};
  assign diff    = a_i - b_i;
  assign sgn_ovf = (a_i[W-1] != b_i[W-1]) && (diff[W-1] != a_i[W-1]);

  assign y_o   = sub_i ? diff : sum_w[W-1:0];
  assign ovf_o = sub_i ? sgn_ovf : sum_w[W];

  always_comb begin
    // R2: an unsigned carry means the stored byte wrapped below acc
    if (!sub_i && ovf_o) begin
      a_r2_add_wraps: assert (y_o < a_i) else $error("add carry without wrap");
    end
    // R3: signed overflow flips the sign relative to the minuend
    if (sub_i && ovf_o) begin
      a_r3_sub_sign: assert (y_o[W-1] != a_i[W-1]) else $error("sub overflow sign");
    end
  end

endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] amt_i,
  input  alu_op_e      op_i,
  input  logic         drop_i,
  output logic [W-1:0] y_o,
  output logic         drop_o,
  output logic         drop_we_o
);

  localparam int SW = $clog2(W);

  logic          zero_amt;
  logic          sat;
  logic [SW-1:0] n;
  logic [W:0]    rsh;
  logic [W:0]    ash;
  logic [W:0]    lsh;
  logic [2*W-1:0] rot;

  assign zero_amt = (amt_i == '0);
  assign sat      = (amt_i >= W[W-1:0]);
  assign n        = amt_i[SW-1:0];

  // the guard bit next to the data holds the last bit that left
  assign rsh = {a_i, 1'b0} >> n;
  assign ash = $signed({a_i, 1'b0}) >>> n;
  assign lsh = {1'b0, a_i} << n;
  assign rot = {a_i, a_i} << n;

  always_comb begin
    y_o       = a_i;
    drop_o    = 1'b0;
    drop_we_o = 1'b0;
    if (op_i == OP_ROL) begin
      y_o = rot[2*W-1:W];
    end else if (is_dist_shift(op_i) && !zero_amt) begin
      drop_we_o = 1'b1;
      case (op_i)
        OP_SHR, OP_SHRC: begin
          y_o    = sat ? '0 : rsh[W:1];
          drop_o = sat ? 1'b0 : rsh[0];
          if (op_i == OP_SHRC) y_o[W-1] = drop_i;
        end
        OP_SHL, OP_SHLC: begin
          y_o    = sat ? '0 : lsh[W-1:0];
          drop_o = sat ? 1'b0 : lsh[W];
          if (op_i == OP_SHLC) y_o[0] = drop_i;
        end
        default: begin
          y_o    = sat ? {W{a_i[W-1]}} : ash[W:1];
          drop_o = sat ? a_i[W-1] : ash[0];
        end
      endcase
    end
  end

  always_comb begin
    // R11: zero distance keeps the accumulator and the flag
    if (is_dist_shift(op_i) && zero_amt) begin
      a_r11_zero_dist: assert (y_o == a_i && !drop_we_o) else $error("zero shift altered state");
    end
    // R12: rotation loses no bits
    if (op_i == OP_ROL) begin
      a_r12_rot_keeps_bits: assert ($countones(y_o) == $countones(a_i) && !drop_we_o)
        else $error("rotate lost bits");
    end
    // R9: arithmetic shift keeps the sign
    if (op_i == OP_SAR) begin
      a_r9_sar_sign: assert (y_o[W-1] == a_i[W-1]) else $error("sar changed sign");
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic [3:0]   op_i,
  input  logic         drop_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         ovf_we_o,
  output logic         drop_o,
  output logic         drop_we_o
);

  alu_op_e      op;
  logic [W-1:0] lg_y;
  logic [W-1:0] as_y;
  logic         as_ovf;
  logic [W-1:0] sh_y;
  logic         sh_drop;
  logic         sh_we;
  logic         is_arith;
  logic         is_shift;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign is_shift = is_dist_shift(op) || (op == OP_ROL);

  acc_logic_unit #(.W(W)) u_logic (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (op_i[1:0]),
    .y_o   (lg_y)
  );

  acc_addsub #(.W(W)) u_addsub (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sub_i (op == OP_SUB),
    .y_o   (as_y),
    .ovf_o (as_ovf)
  );

  acc_shifter #(.W(W)) u_shift (
    .a_i       (acc_i),
    .amt_i     (opnd_i),
    .op_i      (op),
    .drop_i    (drop_i),
    .y_o       (sh_y),
    .drop_o    (sh_drop),
    .drop_we_o (sh_we)
  );

  always_comb begin
    case (op)
      OP_AND, OP_OR, OP_NAND, OP_NOR: res_o = lg_y;
      OP_ADD, OP_SUB:                 res_o = as_y;
      OP_MOV:                         res_o = opnd_i;
      OP_MOVN:                        res_o = ~opnd_i;
      OP_HLD0, OP_HLD1:               res_o = acc_i;
      default:                        res_o = sh_y;
    endcase
  end

  assign ovf_we_o  = is_arith;
  assign ovf_o     = is_arith & as_ovf;
  assign drop_we_o = is_shift & sh_we;
  assign drop_o    = is_shift & sh_drop;

  always_comb begin
    // R4: only add and subtract touch overflow
    if (!is_arith) begin
      a_r4_no_ovf_write: assert (!ovf_we_o && !ovf_o) else $error("stray overflow write");
    end
    // R14: an unwritten dropoff reads as zero
    if (!drop_we_o) begin
      a_r14_drop_quiet: assert (!drop_o) else $error("dropoff without enable");
    end
    // R13: pass-through codes leave both flags alone
    if (op_i[3:2] == 2'b11) begin
      a_r13_pass_quiet: assert (!drop_we_o && !ovf_we_o) else $error("pass op wrote flag");
    end
  end

endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;

  typedef struct {
    logic [3:0] op;
    logic [7:0] amt;
    logic [7:0] res;
    logic       ovf;
    logic       ovf_we;
    logic       drop;
    logic       drop_we;
  } exp_t;

  logic       clk;
  logic [7:0] acc, opnd, res;
  logic [3:0] op;
  logic       dropi, ovf, ovf_we, drop, drop_we;
  int         n_cmp = 0;
  int         n_bad = 0;
  exp_t       sb[$];

  acc_alu u0 (
    .acc_i(acc), .opnd_i(opnd), .op_i(op), .drop_i(dropi),
    .res_o(res), .ovf_o(ovf), .ovf_we_o(ovf_we),
    .drop_o(drop), .drop_we_o(drop_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string tag_of(logic [3:0] o, logic [7:0] b);
    if (o <= 4'd3) return "R1";
    if (o == 4'd4) return "R2";
    if (o == 4'd5) return "R3";
    if (o >= 4'd12) return "R13";
    if (o == 4'd11) return "R12";
    if (b == 8'd0) return "R11";
    if (b >= 8'd8) return "R10";
    case (o)
      4'd6:    return "R5";
      4'd7:    return "R6";
      4'd8:    return "R7";
      4'd9:    return "R8";
      default: return "R9";
    endcase
  endfunction

  // bit-serial reference built from the requirements
  function automatic exp_t model(logic [3:0] o, logic [7:0] a, logic [7:0] b, logic d);
    exp_t e;
    int   s;
    int   sv;
    logic [7:0] r;
    logic out;
    e.op = o; e.amt = b; e.res = a;
    e.ovf = 1'b0; e.ovf_we = 1'b0; e.drop = 1'b0; e.drop_we = 1'b0;
    r = a; out = 1'b0;
    case (o)
      4'd0: e.res = a & b;
      4'd1: e.res = a | b;
      4'd2: e.res = ~(a & b);
      4'd3: e.res = ~(a | b);
      4'd4: begin
        s = int'(a) + int'(b);
        e.res = 8'(s); e.ovf = (s > 255); e.ovf_we = 1'b1;
      end
      4'd5: begin
        sv = int'($signed(a)) - int'($signed(b));
        e.res = a - b; e.ovf = (sv > 127) || (sv < -128); e.ovf_we = 1'b1;
      end
      4'd6, 4'd7, 4'd8, 4'd9, 4'd10: begin
        if (b != 8'd0) begin
          e.drop_we = 1'b1;
          if (b >= 8'd8) begin
            r = (o == 4'd10) ? {8{a[7]}} : 8'h00;
            out = (o == 4'd10) ? a[7] : 1'b0;
          end else begin
            for (int k = 0; k < int'(b); k++) begin
              if (o == 4'd8 || o == 4'd9) begin
                out = r[7]; r = {r[6:0], 1'b0};
              end else begin
                out = r[0]; r = {(o == 4'd10) ? r[7] : 1'b0, r[7:1]};
              end
            end
          end
          if (o == 4'd7) r[7] = d;
          if (o == 4'd9) r[0] = d;
          e.res = r; e.drop = out;
        end
      end
      4'd11: begin
        for (int k = 0; k < int'(b % 8); k++) r = {r[6:0], r[7]};
        e.res = r;
      end
      4'd12: e.res = b;
      4'd13: e.res = ~b;
      default: e.res = a;
    endcase
    return e;
  endfunction

  task automatic drive(logic [3:0] o, logic [7:0] a, logic [7:0] b, logic d);
    @(posedge clk);
    #1;
    op = o; acc = a; opnd = b; dropi = d;
    sb.push_back(model(o, a, b, d));
  endtask

  task automatic cmp(string t, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      string t;
      e = sb.pop_front();
      t = tag_of(e.op, e.amt);
      cmp(t, "res", int'(res), int'(e.res));
      cmp((e.op == 4'd4 || e.op == 4'd5) ? t : "R4", "ovf", int'({ovf_we, ovf}), int'({e.ovf_we, e.ovf}));
      cmp(e.drop_we ? t : "R14", "drop", int'({drop_we, drop}), int'({e.drop_we, e.drop}));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] accs [5];
    logic [7:0] amts [7];
    accs = '{8'h00, 8'h81, 8'hA5, 8'h7F, 8'hFF};
    amts = '{8'd0, 8'd1, 8'd3, 8'd7, 8'd8, 8'd9, 8'd200};
    op = 4'd0; acc = 8'h00; opnd = 8'h00; dropi = 1'b0;
    // idle inputs: R1 with zeros, no flag writes
    drive(4'd0, 8'h00, 8'h00, 1'b0);
    // R2 carry corners
    drive(4'd4, 8'd200, 8'd100, 1'b0);
    drive(4'd4, 8'hFF, 8'h01, 1'b0);
    drive(4'd4, 8'h7F, 8'h01, 1'b0);
    // R3 signed corners
    drive(4'd5, 8'h7F, 8'hFF, 1'b0);
    drive(4'd5, 8'h80, 8'h01, 1'b0);
    drive(4'd5, 8'h00, 8'h01, 1'b0);
    // R6 / R8 chained with inserted bit opposite to the leaving one
    drive(4'd7, 8'h01, 8'd1, 1'b0);
    drive(4'd7, 8'h00, 8'd1, 1'b1);
    drive(4'd9, 8'h80, 8'd1, 1'b0);
    drive(4'd9, 8'h00, 8'd1, 1'b1);
    drive(4'd9, 8'h55, 8'd8, 1'b1);
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 7; j++)
          for (int d = 0; d < 2; d++)
            drive(4'(o), accs[i], amts[j], 1'(d));
    for (int k = 0; k < 400; k++)
      drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom_range(0, 12)), 1'($urandom));
    @(posedge clk);
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule